// File: doc/BRIEF.md
# Prefetch Hint Dispatch

This block takes one decoded prefetch-hint operation at a time and turns it into a fill request for the cache hierarchy, or retires it quietly. Each operation arrives with its two escape bytes, the ModRM byte that carries a 3-bit locality selector, a byte address, a fault flag and one presence bit per cache level. The block clears the byte-offset bits of the address so that the request names the whole line. It maps the selector onto the set of levels to fill. It then issues a single request over a valid/ready handshake, or drops the operation without any request.

A dropped operation never raises an exception and changes no flag. Each operation ends in exactly one completion pulse that says whether it was issued or dropped. Only one operation is in flight at a time, so completions come out in input order. A configuration input can fold the two farther-reaching hints into the all-levels hint.

Top module: `pf_hint_dispatch`

## Requirements
- R1: An operation is recognised only when `in_esc0` is 0x0F and `in_esc1` is 0x18. Any other byte pair is dropped without a request.
- R2: The selector is `in_modrm[5:3]`. In `req_levels`, bit 0 is L1, bit 1 is L2 and bit 2 is L3. Selector 1 requests 3'b111, selector 2 requests 3'b110 and selector 3 requests 3'b100, each with `req_nt` = 0.
- R3: Selector 0 is the non-temporal hint. It requests 3'b001 with `req_nt` = 1, which means a single-way allocation in L1.
- R4: `req_addr` equals `in_addr` with its low log2(LINE_BYTES) bits cleared. LINE_BYTES is at least 32, and its default is 64.
- R5: Each selector has a nearest target level: L1 for selectors 0 and 1, L2 for selector 2 and L3 for selector 3. The operation is dropped if any `in_present` bit is set from L1 up to and including that level. Presence in a farther level does not block the request.
- R6: An operation that arrives with `in_fault` = 1 is dropped.
- R7: Selectors 4 to 7 are dropped.
- R8: When `cfg_alias` = 1, selectors 2 and 3 behave exactly like selector 1, in both the level mask and the presence check. Selectors 0 and 1 are unaffected.
- R9: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_levels` and `req_nt` hold stable. `in_ready` is low while a request is pending, and inputs offered in that time are ignored.
- R10: Every accepted operation yields exactly one `done_valid` pulse. A dropped operation pulses with `done_issued` = 0 one cycle after acceptance. An issued one pulses with `done_issued` = 1 one cycle after the request handshake.
- R11: While reset is asserted, and right after it, `req_valid` = 0, `done_valid` = 0 and `in_ready` = 1. This holds even if a request was pending when reset arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block can accept an operation |
| in_esc0 | input | 8 | First escape byte |
| in_esc1 | input | 8 | Second escape byte |
| in_modrm | input | 8 | ModRM byte, selector in bits 5:3 |
| in_addr | input | ADDR_W | Byte address of the prefetch |
| in_fault | input | 1 | Memory fault detected for this operation |
| in_present | input | LVL_N | Line presence per level, bit 0 = L1 |
| cfg_alias | input | 1 | Fold selectors 2 and 3 into selector 1 |
| req_valid | output | 1 | Fill request pending |
| req_ready | input | 1 | Fill request accepted by the hierarchy |
| req_addr | output | ADDR_W | Line-aligned request address |
| req_levels | output | LVL_N | Levels to fill, bit 0 = L1 |
| req_nt | output | 1 | Non-temporal, single-way fill |
| done_valid | output | 1 | Completion pulse |
| done_issued | output | 1 | 1 = request issued, 0 = dropped |

## Verification
The bench targets the presence rule at its edges. A line held only in a farther level must still be fetched, and a line held at the nearest target level must not be. A design that compared against the wrong level would issue redundant fills or skip needed ones. Alias mode is checked with a presence pattern that only the folded selector passes, so a half-applied alias, with the mask changed but the check not, shows up as a wrong drop.

Back-pressure is tested while a second operation is offered during the stall. A design that let it in would corrupt the held request or produce an extra completion. Faults, bad escape bytes and reserved selectors must each give one pulse with the issued flag low and no request. Reset in the middle of a stalled request must clear it.

// File: rtl/prefetch_pkg.sv
// Shared constants and helpers for the prefetch dispatch block.
// Assumes a three-level hierarchy, with bit 0 of every level vector being L1.
package prefetch_pkg;
    localparam int LVL_N      = 3;
    localparam int SEL_W      = 3;
    localparam logic [7:0] ESC_FIRST  = 8'h0F;
    localparam logic [7:0] ESC_SECOND = 8'h18;
    localparam logic [SEL_W-1:0] SEL_NONTEMP = 3'd0;
    localparam logic [SEL_W-1:0] SEL_ALL     = 3'd1;
    localparam logic [SEL_W-1:0] SEL_FROM_L2 = 3'd2;
    localparam logic [SEL_W-1:0] SEL_FROM_L3 = 3'd3;

    // Index of the nearest level a legal selector fills (0 = L1).
    function automatic logic [1:0] nearest_level(input logic [SEL_W-1:0] sel);
        nearest_level = (sel == SEL_NONTEMP) ? 2'd0 : 2'(sel - 3'd1);
    endfunction
endpackage

// File: rtl/pf_hint_decode.sv
// Combinational decode of one prefetch operation: checks the escape bytes,
// applies alias folding, builds the level mask and decides issue or drop.
// Assumes LVL_N >= 3 so that every legal selector has a target level.
module pf_hint_decode
    import prefetch_pkg::*;
(
    input  logic [7:0]       esc0,
    input  logic [7:0]       esc1,
    input  logic [SEL_W-1:0] sel,
    input  logic             fault,
    input  logic [LVL_N-1:0] present,
    input  logic             alias_en,
    output logic             issue,
    output logic [LVL_N-1:0] levels,
    output logic             nt
);
    logic             opc_ok;
    logic [SEL_W-1:0] eff_sel;
    logic [1:0]       near;
    logic [LVL_N-1:0] check_mask;
    logic             hit_close;

    // Recognise the escape pair and fold aliased selectors.
    always_comb begin
        opc_ok  = (esc0 == ESC_FIRST) && (esc1 == ESC_SECOND);
        eff_sel = (alias_en && (sel == SEL_FROM_L2 || sel == SEL_FROM_L3)) ? SEL_ALL : sel;
        near    = nearest_level(eff_sel);
        nt      = (eff_sel == SEL_NONTEMP);
    end

    // Build the fill mask and the mask of levels that suppress the fill.
    always_comb begin
        for (int i = 0; i < LVL_N; i++) begin
            levels[i]     = nt ? (i == 0) : (i >= int'(near));
            check_mask[i] = (i <= int'(near));
        end
        hit_close = |(present & check_mask);
    end

    // Issue only for a legal, fault-free operation whose line is not already close.
    always_comb begin
        issue = opc_ok && !eff_sel[SEL_W-1] && !fault && !hit_close;
    end
endmodule

// File: rtl/pf_req_slot.sv
// Single-entry holding register for the outgoing fill request, plus the
// completion pulse generator. Assumes load and drop are never both high and
// only arrive while the slot is empty.
module pf_req_slot #(
    parameter int ADDR_W = 32,
    parameter int LVL_N  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              drop,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [LVL_N-1:0]  load_levels,
    input  logic              load_nt,
    input  logic              req_ready,
    output logic              req_valid,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LVL_N-1:0]  req_levels,
    output logic              req_nt,
    output logic              done_valid,
    output logic              done_issued
);
    logic handshake;
    assign handshake = req_valid && req_ready;

    // Request valid flag: set on load, cleared on handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)         req_valid <= 1'b0;
        else if (load)      req_valid <= 1'b1;
        else if (handshake) req_valid <= 1'b0;
    end

    // Request payload: captured on load and held until the next load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_addr   <= '0;
            req_levels <= '0;
            req_nt     <= 1'b0;
        end else if (load) begin
            req_addr   <= load_addr;
            req_levels <= load_levels;
            req_nt     <= load_nt;
        end
    end

    // Completion pulse: one cycle after a drop or after a handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid  <= 1'b0;
            done_issued <= 1'b0;
        end else begin
            done_valid  <= drop || handshake;
            done_issued <= handshake;
        end
    end

    a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_levels) && $stable(req_nt));
    a_r9_no_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !load && !drop);
    a_r10_issued_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
        done_issued |-> done_valid);
    a_r10_handshake_completes: assert property (@(posedge clk) disable iff (!rst_n)
        handshake |=> done_valid && done_issued);
    a_r2_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> req_levels != '0);
endmodule

// File: rtl/pf_hint_dispatch.sv
// Top of the prefetch hint dispatcher. Accepts one operation when the request
// slot is empty, aligns its address to a line, decodes the hint and either
// loads the slot or retires the operation as a no-op.
// Assumes LINE_BYTES is a power of two of at least 32.
module pf_hint_dispatch
    import prefetch_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_esc0,
    input  logic [7:0]        in_esc1,
    input  logic [7:0]        in_modrm,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic              in_fault,
    input  logic [LVL_N-1:0]  in_present,
    input  logic              cfg_alias,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [ADDR_W-1:0] req_addr,
    output logic [LVL_N-1:0]  req_levels,
    output logic              req_nt,
    output logic              done_valid,
    output logic              done_issued
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << OFF_W) - ADDR_W'(1));

    logic              accept;
    logic              dec_issue;
    logic [LVL_N-1:0]  dec_levels;
    logic              dec_nt;
    logic [ADDR_W-1:0] line_addr;
    logic              unused_modrm;

    assign unused_modrm = ^{in_modrm[7:6], in_modrm[2:0]};

    // Handshake on the input side: accept only into an empty slot.
    always_comb begin
        in_ready  = !req_valid;
        accept    = in_valid && in_ready;
        line_addr = in_addr & LINE_MASK;
    end

    pf_hint_decode u_decode (
        .esc0     (in_esc0),
        .esc1     (in_esc1),
        .sel      (in_modrm[5:3]),
        .fault    (in_fault),
        .present  (in_present),
        .alias_en (cfg_alias),
        .issue    (dec_issue),
        .levels   (dec_levels),
        .nt       (dec_nt)
    );

    pf_req_slot #(.ADDR_W(ADDR_W), .LVL_N(LVL_N)) u_slot (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept && dec_issue),
        .drop        (accept && !dec_issue),
        .load_addr   (line_addr),
        .load_levels (dec_levels),
        .load_nt     (dec_nt),
        .req_ready   (req_ready),
        .req_valid   (req_valid),
        .req_addr    (req_addr),
        .req_levels  (req_levels),
        .req_nt      (req_nt),
        .done_valid  (done_valid),
        .done_issued (done_issued)
    );

    a_r4_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr & ~LINE_MASK) == '0);
    a_r6_fault_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_fault |=> !req_valid && done_valid && !done_issued);
    a_r1_bad_escape_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (in_esc0 != 8'h0F || in_esc1 != 8'h18) |=> !req_valid && done_valid);
    a_r7_reserved_drops: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_modrm[5] |=> !req_valid && !done_issued);
    a_r3_nt_single_level: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_nt |-> req_levels == 3'b001);
endmodule

// File: tb/test_pf_hint_dispatch.sv
module test_pf_hint_dispatch;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_esc0 = 8'h0F;
    logic [7:0]  in_esc1 = 8'h18;
    logic [7:0]  in_modrm = 8'h00;
    logic [31:0] in_addr = '0;
    logic        in_fault = 1'b0;
    logic [2:0]  in_present = '0;
    logic        cfg_alias = 1'b0;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [2:0]  req_levels;
    logic        req_nt;
    logic        done_valid;
    logic        done_issued;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pf_hint_dispatch i_pf_hint_dispatch (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_esc0(in_esc0), .in_esc1(in_esc1), .in_modrm(in_modrm),
        .in_addr(in_addr), .in_fault(in_fault), .in_present(in_present),
        .cfg_alias(cfg_alias), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_levels(req_levels), .req_nt(req_nt),
        .done_valid(done_valid), .done_issued(done_issued)
    );

    typedef struct packed {
        logic [2:0] sel;
        logic       esc_ok;
        logic       fault;
        logic [2:0] present;
        logic       alias_on;
        logic       exp_issue;
        logic [2:0] exp_lvl;
        logic       exp_nt;
        logic [1:0] delay;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b111, 1'b0, 2'd0}, // R2 R4 all levels
        '{3'd2, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b110, 1'b0, 2'd2}, // R2 R9 from L2
        '{3'd3, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b100, 1'b0, 2'd1}, // R2 from L3
        '{3'd0, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b001, 1'b1, 2'd0}, // R3 non-temporal
        '{3'd1, 1'b1, 1'b0, 3'b001, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R5 in L1
        '{3'd2, 1'b1, 1'b0, 3'b100, 1'b0, 1'b1, 3'b110, 1'b0, 2'd0}, // R5 farther only
        '{3'd2, 1'b1, 1'b0, 3'b010, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R5 at target
        '{3'd3, 1'b1, 1'b0, 3'b100, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R5 at L3
        '{3'd0, 1'b1, 1'b0, 3'b110, 1'b0, 1'b1, 3'b001, 1'b1, 2'd3}, // R5 R3 NT checks L1 only
        '{3'd1, 1'b1, 1'b1, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R6 fault
        '{3'd5, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R7 reserved
        '{3'd7, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R7 reserved
        '{3'd1, 1'b0, 1'b0, 3'b000, 1'b0, 1'b0, 3'b000, 1'b0, 2'd0}, // R1 bad escape
        '{3'd3, 1'b1, 1'b0, 3'b010, 1'b1, 1'b1, 3'b111, 1'b0, 2'd0}, // R8 alias from L3
        '{3'd2, 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 3'b111, 1'b0, 2'd1}, // R8 alias from L2
        '{3'd0, 1'b1, 1'b0, 3'b000, 1'b1, 1'b1, 3'b001, 1'b1, 2'd0}, // R8 NT unchanged
        '{3'd3, 1'b1, 1'b0, 3'b001, 1'b1, 1'b0, 3'b000, 1'b0, 2'd0}  // R8 aliased L1 check
    };

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offer one operation, then follow it to completion, checking every cycle.
    task automatic run_op(input vec_t v, input logic [31:0] addr);
        logic [31:0] exp_addr;
        exp_addr = addr & ~32'h3F;
        @(negedge clk);
        in_valid   = 1'b1;
        in_esc0    = 8'h0F;
        in_esc1    = v.esc_ok ? 8'h18 : 8'h19;
        in_modrm   = {2'b01, v.sel, 3'b101};
        in_addr    = addr;
        in_fault   = v.fault;
        in_present = v.present;
        cfg_alias  = v.alias_on;
        chk(in_ready == 1'b1, "R9 ready when idle", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (v.exp_issue) begin
            chk(req_valid == 1'b1, "R2 issue", 32'(req_valid), 32'd1);
            chk(req_addr == exp_addr, "R4 aligned address", req_addr, exp_addr);
            chk(req_levels == v.exp_lvl, "R2 R3 R8 level mask", 32'(req_levels), 32'(v.exp_lvl));
            chk(req_nt == v.exp_nt, "R3 nt attribute", 32'(req_nt), 32'(v.exp_nt));
            chk(done_valid == 1'b0, "R10 no early done", 32'(done_valid), 32'd0);
            for (int d = 0; d < int'(v.delay); d++) begin
                // R9: a competing operation is offered and must be ignored
                in_valid = 1'b1;
                in_addr  = 32'hDEAD_BEEF;
                in_modrm = 8'h00;
                @(posedge clk);
                @(negedge clk);
                chk(in_ready == 1'b0, "R9 back-pressure", 32'(in_ready), 32'd0);
                chk(req_valid && req_addr == exp_addr && req_levels == v.exp_lvl && req_nt == v.exp_nt,
                    "R9 held request", req_addr, exp_addr);
                chk(done_valid == 1'b0, "R10 no done while stalled", 32'(done_valid), 32'd0);
            end
            in_valid  = 1'b0;
            req_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            req_ready = 1'b0;
            chk(req_valid == 1'b0, "R10 request retired", 32'(req_valid), 32'd0);
            chk(done_valid && done_issued, "R10 issued completion", {30'd0, done_valid, done_issued}, 32'd3);
        end else begin
            chk(req_valid == 1'b0, "R1 R5 R6 R7 no request", 32'(req_valid), 32'd0);
            chk(done_valid && !done_issued, "R10 dropped completion", {30'd0, done_valid, done_issued}, 32'd2);
        end
        @(posedge clk);
        @(negedge clk);
        chk(done_valid == 1'b0, "R10 single pulse", 32'(done_valid), 32'd0);
        chk(req_valid == 1'b0, "R10 slot empty", 32'(req_valid), 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R11: reset with an operation already offered
        in_valid = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_valid == 1'b0, "R11 reset req_valid", 32'(req_valid), 32'd0);
        chk(done_valid == 1'b0, "R11 reset done_valid", 32'(done_valid), 32'd0);
        chk(in_ready == 1'b1, "R11 reset in_ready", 32'(in_ready), 32'd1);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_valid == 1'b0 && done_valid == 1'b0, "R11 after reset", 32'(req_valid), 32'd0);

        for (int i = 0; i < NV; i++)
            run_op(VECS[i], 32'h1000_0000 + 32'(i) * 32'h0101_0137);

        // R4: address already aligned and address with all offset bits set
        run_op('{3'd1, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b111, 1'b0, 2'd0}, 32'h0000_0040);
        run_op('{3'd3, 1'b1, 1'b0, 3'b000, 1'b0, 1'b1, 3'b100, 1'b0, 2'd0}, 32'hFFFF_FFFF);
        // R1: wrong first escape byte
        @(negedge clk);
        in_valid = 1'b1; in_esc0 = 8'h0E; in_esc1 = 8'h18; in_modrm = 8'h08;
        in_fault = 1'b0; in_present = '0; cfg_alias = 1'b0;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req_valid == 1'b0 && done_valid && !done_issued, "R1 first escape byte", 32'(req_valid), 32'd0);
        in_esc0 = 8'h0F;

        // R11: reset while a request is stalled
        @(negedge clk);
        in_valid = 1'b1; in_esc1 = 8'h18; in_modrm = 8'h08; in_addr = 32'h0000_1234;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk(req_valid == 1'b1, "R11 pending before reset", 32'(req_valid), 32'd1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(req_valid == 1'b0 && done_valid == 1'b0, "R11 reset clears pending", 32'(req_valid), 32'd0);
        chk(in_ready == 1'b1, "R11 ready after clear", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule